// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block is a watchdog counter that a host programs and services through a small synchronous register bus. The host writes a timer value, releases the halt control and then keeps the watchdog alive by writing a reload strobe before the count runs out. The counter decrements once for each pulse on the tick-enable input while it is not halted.

If the host misses the first deadline, the block sets a first-stage timeout flag and can raise an interrupt request. It then reloads itself automatically and counts a second full period. If that period also expires, the block sets a sticky second-stage flag and pulses a system reset request, unless the no-reboot control suppresses it. The second-stage flag and a repeat-boot flag sit in a power-on reset domain, so they keep their values through the system reset that the block itself requests. Software can therefore recognise a watchdog-caused restart.

Register addresses (3-bit, 16-bit data): 0 first status, 1 second status, 2 control, 3 reload strobe, 4 timer value, 5 configuration, 6 live count, 7 stage.

Top module: `wdog_twostage`

## Requirements
- R1: After `rst_n` and `por_n` are released, these reads return the following values: status registers 0x0000, control 0x0800 (halted), timer value 4, configuration 0x0002 (no-reboot set, interrupt off), count 4 and stage 0. `irq` and `rst_req` are low.
- R2: A write to address 4 stores the 16-bit write value clamped to the range 2 to 1023, and address 4 reads back the stored value.
- R3: A write to address 4 leaves the live count (address 6) unchanged. A write to address 3 loads the count from the stored timer value only when any of write bits 4..0 is 1; otherwise the write has no effect.
- R4: While control bit 11 (halt) is 1, ticks leave the count unchanged. While it is 0, each tick lowers the count by one.
- R5: A control write stores only bit 11 (halt) and bit 9 (retained). Control reads return those two bits and zero in every other position.
- R6: When the count is 1 and a tick arrives in stage 0, the block sets bit 0 of address 0, reloads the count and enters stage 1. `irq` equals that flag ANDed with configuration bit 0.
- R7: When the count is 1 and a tick arrives in stage 1, the block sets bit 0 of address 1, reloads the count and returns to stage 0. `rst_req` is high for exactly the one cycle after that tick edge. If bit 0 of address 1 was already set, bit 1 (repeat boot) is also set.
- R8: A status bit is cleared only by writing 1 to its own position. Writing 0 has no effect. On address 1, each write clears only the bits it sets. If a hardware set and a clear write fall in the same cycle, the set wins.
- R9: Configuration bit 1 (no-reboot) resets to 1. When it is 1, or when the `nr_lock` input is 1, the second-stage expiry raises no `rst_req`. Configuration bit 1 reads back the effective value, so a clearing write under `nr_lock` still reads 1.
- R10: A valid reload write returns the block to stage 0 with the count equal to the timer value. This cancels a pending second stage. A reload in the same cycle as an expiring tick wins, and no flag or reset request results.
- R11: Address 1 bits keep their values while `rst_n` is asserted and are reset only by `por_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; clears the sticky second-stage flags |
| rst_n | input | 1 | System reset, active low; clears everything else |
| tick | input | 1 | Countdown enable pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| nr_lock | input | 1 | Hard lock that forces no-reboot on |
| irq | output | 1 | First-stage interrupt request |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
Two pairs of events can fall in the same cycle. The bench provokes the first pair by driving a reload write in the exact cycle that the count sits at 1 in stage 1 with a tick present. It judges the outcome by checking that `rst_req` stays low, the stage returns to 0 and the count equals the timer value. For the second pair, the bench issues a write-one clear of the first-stage flag in the same cycle as the expiring tick, then checks that the flag reads 1 and the stage has advanced.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [2:0] ADDR_STAT1  = 3'd0;
  localparam logic [2:0] ADDR_STAT2  = 3'd1;
  localparam logic [2:0] ADDR_CTRL   = 3'd2;
  localparam logic [2:0] ADDR_RELOAD = 3'd3;
  localparam logic [2:0] ADDR_TVAL   = 3'd4;
  localparam logic [2:0] ADDR_CFG    = 3'd5;
  localparam logic [2:0] ADDR_COUNT  = 3'd6;
  localparam logic [2:0] ADDR_STAGE  = 3'd7;

  // Bound a requested period to the legal window.
  function automatic int unsigned clamp_tval(input int unsigned raw,
                                             input int unsigned lo,
                                             input int unsigned hi);
    if (raw < lo) return lo;
    if (raw > hi) return hi;
    return raw;
  endfunction

  // A reload write counts only if one of its key bits is set.
  function automatic logic reload_key(input logic [4:0] low);
    return |low;
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned DW       = 16,
  parameter int unsigned TW       = 10,
  parameter int unsigned TMIN     = 2,
  parameter int unsigned TRST     = 4,
  parameter int unsigned HALT_BIT = 11,
  parameter int unsigned KEEP_BIT = 9
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [2:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          nr_lock,
  input  logic          exp1,
  input  logic          exp2,
  input  logic [TW-1:0] count,
  input  logic          stage,
  output logic [DW-1:0] bus_rdata,
  output logic          halt,
  output logic [TW-1:0] tval,
  output logic          reload_req,
  output logic          irq_en,
  output logic          nr_eff,
  output logic          t1_flag,
  output logic          t2_flag,
  output logic          boot_flag
);
  localparam int unsigned TMAX = (1 << TW) - 1;

  logic keep_bit;
  logic nrb_q;
  logic wr_stat1, wr_stat2, wr_ctrl, wr_reload, wr_tval, wr_cfg;

  assign wr_stat1  = bus_wr && (bus_addr == ADDR_STAT1);
  assign wr_stat2  = bus_wr && (bus_addr == ADDR_STAT2);
  assign wr_ctrl   = bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_reload = bus_wr && (bus_addr == ADDR_RELOAD);
  assign wr_tval   = bus_wr && (bus_addr == ADDR_TVAL);
  assign wr_cfg    = bus_wr && (bus_addr == ADDR_CFG);

  assign reload_req = wr_reload && reload_key(bus_wdata[4:0]);
  assign nr_eff     = nrb_q | nr_lock;

  // First-stage flag: system reset domain, hardware set beats clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        t1_flag <= 1'b0;
    else if (exp1)                     t1_flag <= 1'b1;
    else if (wr_stat1 && bus_wdata[0]) t1_flag <= 1'b0;
  end

  // Sticky second-stage flags: power-on domain only.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      t2_flag   <= 1'b0;
      boot_flag <= 1'b0;
    end else begin
      if (exp2)                          t2_flag <= 1'b1;
      else if (wr_stat2 && bus_wdata[0]) t2_flag <= 1'b0;
      if (exp2 && t2_flag)               boot_flag <= 1'b1;
      else if (wr_stat2 && bus_wdata[1]) boot_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt     <= 1'b1;
      keep_bit <= 1'b0;
      irq_en   <= 1'b0;
      nrb_q    <= 1'b1;
      tval     <= TW'(TRST);
    end else begin
      if (wr_ctrl) begin
        halt     <= bus_wdata[HALT_BIT];
        keep_bit <= bus_wdata[KEEP_BIT];
      end
      if (wr_cfg) begin
        irq_en <= bus_wdata[0];
        nrb_q  <= bus_wdata[1];
      end
      if (wr_tval)
        tval <= TW'(clamp_tval(32'(bus_wdata), TMIN, TMAX));
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_STAT1: bus_rdata[0] = t1_flag;
      ADDR_STAT2: begin
        bus_rdata[0] = t2_flag;
        bus_rdata[1] = boot_flag;
      end
      ADDR_CTRL: begin
        bus_rdata[HALT_BIT] = halt;
        bus_rdata[KEEP_BIT] = keep_bit;
      end
      ADDR_TVAL:  bus_rdata[TW-1:0] = tval;
      ADDR_CFG: begin
        bus_rdata[0] = irq_en;
        bus_rdata[1] = nr_eff;
      end
      ADDR_COUNT: bus_rdata[TW-1:0] = count;
      ADDR_STAGE: bus_rdata[0] = stage;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int unsigned TW   = 10,
  parameter int unsigned TRST = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          halt,
  input  logic [TW-1:0] tval,
  input  logic          reload_req,
  input  logic          nr_eff,
  output logic [TW-1:0] count,
  output logic          stage,
  output logic          exp1,
  output logic          exp2,
  output logic          rst_req
);
  logic step;
  logic hit;

  assign step = tick && !halt;
  assign hit  = step && (count == TW'(1));
  // A host reload in the same cycle takes precedence over expiry.
  assign exp1 = hit && !stage && !reload_req;
  assign exp2 = hit &&  stage && !reload_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= TW'(TRST);
      stage   <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= exp2 && !nr_eff;
      if (reload_req) begin
        count <= tval;
        stage <= 1'b0;
      end else if (hit) begin
        count <= tval;
        stage <= !stage;
      end else if (step) begin
        count <= count - TW'(1);
      end
    end
  end
endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage #(
  parameter int unsigned DW       = 16,
  parameter int unsigned TW       = 10,
  parameter int unsigned TMIN     = 2,
  parameter int unsigned TRST     = 4,
  parameter int unsigned HALT_BIT = 11,
  parameter int unsigned KEEP_BIT = 9
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bus_wr,
  input  logic [2:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          nr_lock,
  output logic          irq,
  output logic          rst_req
);
  logic          halt;
  logic [TW-1:0] tval;
  logic [TW-1:0] count;
  logic          stage;
  logic          reload_req;
  logic          irq_en;
  logic          nr_eff;
  logic          exp1;
  logic          exp2;
  logic          t1_flag;
  logic          t2_flag;
  logic          boot_flag;

  wdog_regs #(
    .DW(DW), .TW(TW), .TMIN(TMIN), .TRST(TRST),
    .HALT_BIT(HALT_BIT), .KEEP_BIT(KEEP_BIT)
  ) u_regs (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .nr_lock(nr_lock), .exp1(exp1), .exp2(exp2),
    .count(count), .stage(stage),
    .bus_rdata(bus_rdata), .halt(halt), .tval(tval),
    .reload_req(reload_req), .irq_en(irq_en), .nr_eff(nr_eff),
    .t1_flag(t1_flag), .t2_flag(t2_flag), .boot_flag(boot_flag)
  );

  wdog_count #(.TW(TW), .TRST(TRST)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .halt(halt), .tval(tval),
    .reload_req(reload_req), .nr_eff(nr_eff),
    .count(count), .stage(stage), .exp1(exp1), .exp2(exp2),
    .rst_req(rst_req)
  );

  assign irq = t1_flag && irq_en;
endmodule

// File: rtl/wdog_twostage_chk.sv
module wdog_twostage_chk #(
  parameter int unsigned TW   = 10,
  parameter int unsigned TMIN = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          halt,
  input logic [TW-1:0] tval,
  input logic [TW-1:0] count,
  input logic          stage,
  input logic          reload_req,
  input logic          nr_eff,
  input logic          exp1,
  input logic          exp2,
  input logic          t1_flag,
  input logic          t2_flag,
  input logic          rst_req
);
  localparam int unsigned TMAX = (1 << TW) - 1;

  a_r7_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  a_r9_rst_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(exp2) && !$past(nr_eff)));

  a_r4_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !reload_req) |=> ($stable(count) && $stable(stage)));

  a_r10_reload_restart: assert property (@(posedge clk) disable iff (!rst_n)
    reload_req |=> (!stage && (count == $past(tval))));

  a_r6_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(t1_flag) |-> $past(exp1));

  a_r11_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(t2_flag) |-> $past(exp2));

  a_r2_tval_window: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(tval) >= TMIN) && (32'(tval) <= TMAX));
endmodule

bind wdog_twostage wdog_twostage_chk #(.TW(TW), .TMIN(TMIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .halt(halt), .tval(tval), .count(count),
  .stage(stage), .reload_req(reload_req), .nr_eff(nr_eff),
  .exp1(exp1), .exp2(exp2), .t1_flag(t1_flag), .t2_flag(t2_flag),
  .rst_req(rst_req)
);

// File: tb/wdog_twostage_bench.sv
module wdog_twostage_bench;
  localparam int CLK_P = 10;
  localparam logic [2:0] A_ST1 = 3'd0, A_ST2 = 3'd1, A_CTL = 3'd2, A_RLD = 3'd3,
                         A_TV = 3'd4, A_CFG = 3'd5, A_CNT = 3'd6, A_STG = 3'd7;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0, tick = 1'b0, bus_wr = 1'b0, nr_lock = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic irq, rst_req;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  wdog_twostage u_wdog_twostage (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .nr_lock(nr_lock), .irq(irq), .rst_req(rst_req)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [15:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  // Tick and a bus write sampled on the same clock edge.
  task automatic tick_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    tick = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    tick = 1'b0; bus_wr = 1'b0;
  endtask

  function automatic logic [15:0] exp_clamp(input int v);
    return (v < 2) ? 16'd2 : (v > 1023) ? 16'd1023 : 16'(v);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int prev;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk("R1 stat1", A_ST1, 16'h0000);
    rd_chk("R1 stat2", A_ST2, 16'h0000);
    rd_chk("R1 ctrl",  A_CTL, 16'h0800);
    rd_chk("R1 tval",  A_TV,  16'd4);
    rd_chk("R1 cfg",   A_CFG, 16'h0002);
    rd_chk("R1 count", A_CNT, 16'd4);
    rd_chk("R1 stage", A_STG, 16'd0);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 rst_req", {15'd0, rst_req}, 16'd0);

    // R2 clamp sweep; R3 count untouched by tval writes
    for (int v = 0; v < 1100; v++) begin
      wr(A_TV, 16'(v));
      rd_chk("R2 clamp", A_TV, exp_clamp(v));
    end
    wr(A_TV, 16'hFFFF); rd_chk("R2 clamp top", A_TV, 16'd1023);
    wr(A_TV, 16'h8001); rd_chk("R2 clamp high", A_TV, 16'd1023);
    rd_chk("R3 count unchanged by tval", A_CNT, 16'd4);

    // R3 reload key sweep
    prev = 4;
    for (int v = 0; v < 64; v++) begin
      wr(A_TV, 16'(100 + v));
      wr(A_RLD, 16'(v));
      if ((v & 31) != 0) prev = 100 + v;
      rd_chk("R3 reload key", A_CNT, 16'(prev));
    end

    // R5 control layout
    wr(A_CTL, 16'hFFFF); rd_chk("R5 ctrl all", A_CTL, 16'h0A00);
    wr(A_CTL, 16'h0200); rd_chk("R5 ctrl keep", A_CTL, 16'h0200);
    wr(A_CTL, 16'h0800); rd_chk("R5 ctrl halt", A_CTL, 16'h0800);

    // R4 halt and countdown
    wr(A_CFG, 16'h0000);
    wr(A_TV, 16'd6); wr(A_RLD, 16'd1);
    rd_chk("R3 reload load", A_CNT, 16'd6);
    ticks(3); rd_chk("R4 halted", A_CNT, 16'd6);
    wr(A_CTL, 16'h0000);
    ticks(3); rd_chk("R4 running", A_CNT, 16'd3);
    wr(A_CTL, 16'h0800);
    ticks(2); rd_chk("R4 halt again", A_CNT, 16'd3);
    wr(A_CTL, 16'h0000);
    ticks(2); rd_chk("R6 before expiry", A_ST1, 16'd0);
    rd_chk("R4 count one", A_CNT, 16'd1);

    // R6 first expiry
    ticks(1);
    rd_chk("R6 flag", A_ST1, 16'd1);
    rd_chk("R6 stage", A_STG, 16'd1);
    rd_chk("R6 auto reload", A_CNT, 16'd6);
    chk("R6 irq gated off", {15'd0, irq}, 16'd0);
    wr(A_CFG, 16'h0001);
    chk("R6 irq on", {15'd0, irq}, 16'd1);
    wr(A_ST1, 16'hFFFE); rd_chk("R8 zero no effect", A_ST1, 16'd1);
    wr(A_ST1, 16'h0001); rd_chk("R8 clear", A_ST1, 16'd0);
    chk("R6 irq dropped", {15'd0, irq}, 16'd0);

    // R7 second expiry
    ticks(5);
    chk("R7 no early reset", {15'd0, rst_req}, 16'd0);
    ticks(1);
    chk("R7 rst pulse", {15'd0, rst_req}, 16'd1);
    rd_chk("R7 stat2", A_ST2, 16'd1);
    rd_chk("R7 stage back", A_STG, 16'd0);
    rd_chk("R7 stat1 untouched", A_ST1, 16'd0);
    @(negedge clk);
    chk("R7 rst one cycle", {15'd0, rst_req}, 16'd0);

    // R11 survival across system reset
    rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1; @(negedge clk);
    rd_chk("R11 stat2 kept", A_ST2, 16'd1);
    rd_chk("R11 ctrl reset", A_CTL, 16'h0800);
    rd_chk("R11 tval reset", A_TV, 16'd4);

    // R7 repeat boot flag
    wr(A_CFG, 16'h0000); wr(A_TV, 16'd2); wr(A_RLD, 16'd1); wr(A_CTL, 16'h0000);
    ticks(2); rd_chk("R6 stage one", A_STG, 16'd1);
    ticks(2);
    chk("R7 rst again", {15'd0, rst_req}, 16'd1);
    rd_chk("R7 boot flag", A_ST2, 16'd3);
    wr(A_ST2, 16'h0000); rd_chk("R8 stat2 zero write", A_ST2, 16'd3);
    wr(A_ST2, 16'h0001); rd_chk("R8 separate clear t2", A_ST2, 16'd2);
    wr(A_ST2, 16'h0002); rd_chk("R8 separate clear boot", A_ST2, 16'd0);
    wr(A_ST1, 16'h0001);

    // R9 no-reboot
    wr(A_CFG, 16'h0002);
    ticks(2);
    ticks(1);
    @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
    chk("R9 veto", {15'd0, rst_req}, 16'd0);
    rd_chk("R9 flag still set", A_ST2, 16'd1);
    nr_lock = 1'b1;
    wr(A_CFG, 16'h0000); rd_chk("R9 lock readback", A_CFG, 16'h0002);
    ticks(2); ticks(2);
    chk("R9 lock veto", {15'd0, rst_req}, 16'd0);
    nr_lock = 1'b0;
    rd_chk("R9 unlocked", A_CFG, 16'h0000);
    wr(A_ST1, 16'h0001); wr(A_ST2, 16'h0003);

    // R10 reload cancels stage two
    ticks(2); rd_chk("R10 in stage one", A_STG, 16'd1);
    wr(A_RLD, 16'h0010);
    rd_chk("R10 stage cleared", A_STG, 16'd0);
    rd_chk("R10 count restored", A_CNT, 16'd2);
    ticks(2); rd_chk("R10 first again", A_STG, 16'd1);
    rd_chk("R10 no second flag", A_ST2, 16'd0);
    ticks(1);
    tick_wr(A_RLD, 16'h0001);
    chk("R10 reload beats expiry", {15'd0, rst_req}, 16'd0);
    rd_chk("R10 race stage", A_STG, 16'd0);
    rd_chk("R10 race count", A_CNT, 16'd2);
    rd_chk("R10 race flag", A_ST2, 16'd0);

    // R8 hardware set beats same-cycle clear
    wr(A_ST1, 16'h0001);
    ticks(1);
    tick_wr(A_ST1, 16'h0001);
    rd_chk("R8 set wins", A_ST1, 16'd1);
    rd_chk("R8 set wins stage", A_STG, 16'd1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule